// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block keeps the modem control register and the modem status register of a 16550-compatible serial port. Four incoming handshake lines (clear-to-send, data-set-ready, carrier-detect, ring) pass through multi-flop synchronisers. Their synchronised levels are held in the upper nibble of the status register. Any change of level sets a sticky flag in the lower nibble. For the ring line only a trailing edge (1 to 0) counts. A status read returns the register and clears the flags. The control register drives four outgoing lines: request-to-send, terminal-ready, and two general outputs. It also holds a loopback bit.

A small two-state mode machine chooses where the status levels come from. In state `MODE_EXT` they come from the synchronised pins. In state `MODE_LOOP` they come from the control register through a fixed crossed mapping, and the outgoing handshake lines are held inactive. There are two transitions. `EXT_TO_LOOP` is taken on a control write with the loop bit set. `LOOP_TO_EXT` is taken on a control write with the loop bit clear. A modem-status interrupt request is raised whenever the enable input is high and at least one flag is set. Interrupt priority and the register bus decoder sit outside this block.

Top module: `modem_status_ctl`

## Requirements
- R1: After reset the control readback is 0x08 (only OUT2 set), the status value is 0xB0 (carrier, data-set-ready and clear-to-send high, no flags), rts_out, dtr_out and out1_out are 0, out2_out is 1 and irq_out is 0.
- R2: Status bits 7, 5 and 4 hold the carrier, data-set-ready and clear-to-send levels. Any change in one of these levels, in either direction, sets its flag: bit 3, bit 1 or bit 0 respectively.
- R3: A set flag stays set until a status read, and flags from successive changes accumulate.
- R4: Status bit 6 holds the ring level. Its flag, bit 2, is set only when ring falls from 1 to 0, never when it rises.
- R5: During the cycle that sts_rd is high, sts_rdata shows the value before the read. After that edge all four flags are 0, unless a new change arrives in the same cycle.
- R6: A control write keeps only data bits 4..0: DTR in bit 0, RTS in bit 1, OUT1 in bit 2, OUT2 in bit 3, loop in bit 4. Readback bits 7..5 are always 0.
- R7: With the loop bit set, status bits 7, 6, 5 and 4 equal OUT2, OUT1, DTR and RTS of the control register. The external line inputs then have no effect on the status value.
- R8: With the loop bit set, rts_out and dtr_out are 0. out1_out and out2_out always follow the control register. All outputs are active high.
- R9: irq_out is 1 exactly when msi_en is 1 and at least one status flag is set.
- R10: An external line change is not visible at the third-to-last edge before it lands. It appears in the status value after SYNC_STAGES+1 rising edges (three with the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| sts_rd | input | 1 | Status read strobe; clears the flags at the next edge |
| sts_rdata | output | 8 | Status register value |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_in | input | 1 | Clear-to-send line, active high, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, active high, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, active high, asynchronous |
| ri_in | input | 1 | Ring line, active high, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Terminal-ready output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| irq_out | output | 1 | Modem-status interrupt request |

## Verification
If the previous-level register goes wrong, the result is a flag that should not be set, or a missing flag. This shows in sts_rdata[3:0] and irq_out on the edge where the level lands, three edges after the pin moves. A mode machine stuck in the wrong state shows on the next control write: the status levels no longer follow the crossed control bits, or they stop ignoring the pins, and rts_out/dtr_out stay live. A flag register that fails to clear, or clears early, is caught by the status read that follows each stimulus step, one edge after the strobe.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int LINE_CNT = 4;
    // position of each line inside a status nibble
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;
    localparam logic [LINE_CNT-1:0] LVL_RESET = 4'b1011;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    localparam int   CTL_W     = $bits(ctl_t);
    localparam ctl_t CTL_RESET = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};

    typedef enum logic [0:0] {
        MODE_EXT  = 1'b0,
        MODE_LOOP = 1'b1
    } mode_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
    import mdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [7:0]          wdata,
    input  logic [LINE_CNT-1:0] ext_lvl,
    output ctl_t                ctl_q,
    output mode_e               mode_q,
    output logic [LINE_CNT-1:0] lvl_sel,
    output logic                rts_pin,
    output logic                dtr_pin,
    output logic                out1_pin,
    output logic                out2_pin
);
    mode_e mode_d;
    logic  unused_hi;
    assign unused_hi = ^wdata[7:CTL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else if (wr) ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
    end

    // next-state: EXT_TO_LOOP / LOOP_TO_EXT on control writes
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_EXT:  if (wr &&  wdata[CTL_W-1]) mode_d = MODE_LOOP;
            MODE_LOOP: if (wr && !wdata[CTL_W-1]) mode_d = MODE_EXT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_EXT;
        else        mode_q <= mode_d;
    end

    // outputs per state
    always_comb begin
        out1_pin = ctl_q.out1;
        out2_pin = ctl_q.out2;
        unique case (mode_q)
            MODE_EXT: begin
                lvl_sel = ext_lvl;
                rts_pin = ctl_q.rts;
                dtr_pin = ctl_q.dtr;
            end
            MODE_LOOP: begin
                lvl_sel[IDX_DCD] = ctl_q.out2;
                lvl_sel[IDX_RI]  = ctl_q.out1;
                lvl_sel[IDX_DSR] = ctl_q.dtr;
                lvl_sel[IDX_CTS] = ctl_q.rts;
                rts_pin = 1'b0;
                dtr_pin = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mdm_track.sv
module mdm_track
    import mdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINE_CNT-1:0] lvl_in,
    input  logic                rd,
    output logic [LINE_CNT-1:0] lvl_q,
    output logic [LINE_CNT-1:0] flag_q
);
    logic [LINE_CNT-1:0] edge_hit;

    for (genvar b = 0; b < LINE_CNT; b++) begin : g_edge
        if (b == IDX_RI) begin : g_trail
            assign edge_hit[b] = lvl_q[b] & ~lvl_in[b];
        end else begin : g_any
            assign edge_hit[b] = lvl_q[b] ^ lvl_in[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= LVL_RESET;
            flag_q <= '0;
        end else begin
            lvl_q  <= lvl_in;
            flag_q <= (rd ? '0 : flag_q) | edge_hit;
        end
    end
endmodule

// File: rtl/modem_status_ctl.sv
module modem_status_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata,
    input  logic       msi_en,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       dcd_in,
    input  logic       ri_in,
    output logic       rts_out,
    output logic       dtr_out,
    output logic       out1_out,
    output logic       out2_out,
    output logic       irq_out
);
    logic [LINE_CNT-1:0] pin_lvl, ext_lvl, lvl_sel, lvl_q, flag_q;
    ctl_t                ctl_q;
    mode_e               mode_q;

    always_comb begin
        pin_lvl[IDX_CTS] = cts_in;
        pin_lvl[IDX_DSR] = dsr_in;
        pin_lvl[IDX_RI]  = ri_in;
        pin_lvl[IDX_DCD] = dcd_in;
    end

    mdm_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_CNT), .RST_VAL(LVL_RESET)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_lvl), .sync_out(ext_lvl)
    );

    mdm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .ext_lvl(ext_lvl), .ctl_q(ctl_q), .mode_q(mode_q), .lvl_sel(lvl_sel),
        .rts_pin(rts_out), .dtr_pin(dtr_out), .out1_pin(out1_out), .out2_pin(out2_out)
    );

    mdm_track u_track (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl_sel), .rd(sts_rd),
        .lvl_q(lvl_q), .flag_q(flag_q)
    );

    assign ctl_rdata = {{(8-CTL_W){1'b0}}, ctl_q};
    assign sts_rdata = {lvl_q, flag_q};
    assign irq_out   = msi_en & (|flag_q);
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sts_rd,
    input logic [7:0] sts_rdata,
    input logic [7:0] ctl_rdata,
    input logic       msi_en,
    input logic       rts_out,
    input logic       dtr_out,
    input logic       irq_out
);
    assert_level_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sts_rdata[4]) |-> sts_rdata[0]);

    assert_dcd_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sts_rdata[7]) |-> sts_rdata[3]);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_rd |=> ((sts_rdata[3:0] & $past(sts_rdata[3:0])) == $past(sts_rdata[3:0])));

    assert_trailing_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rdata[2]) |-> $fell(sts_rdata[6]));

    assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> ($stable(sts_rdata[7:4]) -> (sts_rdata[3:0] == 4'h0)));

    assert_ctl_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7:5] == 3'b000);

    assert_loop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |-> (!rts_out && !dtr_out));

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (msi_en && (sts_rdata[3:0] != 4'h0)));
endmodule

bind modem_status_ctl mdm_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .ctl_rdata(ctl_rdata), .msi_en(msi_en), .rts_out(rts_out),
    .dtr_out(dtr_out), .irq_out(irq_out)
);

// File: tb/sim_modem_status_ctl.sv
module sim_modem_status_ctl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       msi_en = 1'b0;
    logic       cts_in = 1'b1, dsr_in = 1'b1, dcd_in = 1'b1, ri_in = 1'b0;
    logic       rts_out, dtr_out, out1_out, out2_out, irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_status_ctl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .msi_en(msi_en), .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in),
        .ri_in(ri_in), .rts_out(rts_out), .dtr_out(dtr_out),
        .out1_out(out1_out), .out2_out(out2_out), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // flags expected from one level step (ring counts only 1->0)
    function automatic logic [3:0] step_flags(input logic [3:0] o, input logic [3:0] n);
        logic [3:0] f;
        f = o ^ n;
        f[2] = o[2] & ~n[2];
        return f;
    endfunction

    task automatic set_lines(input logic [3:0] v);
        @(negedge clk);
        {dcd_in, ri_in, dsr_in, cts_in} = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic sts_read(output logic [7:0] v);
        @(negedge clk);
        sts_rd = 1'b1;
        v = sts_rdata;
        @(negedge clk);
        sts_rd = 1'b0;
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] rv;
        logic [3:0] cur, nxt, fl;
        logic [4:0] cv;
        void'($urandom(32'h5EED_1234));

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 ctl", ctl_rdata, 8'h08);
        check("R1 sts", sts_rdata, 8'hB0);
        check("R1 pins", {3'b0, rts_out, dtr_out, out1_out, out2_out, irq_out}, 8'h02);

        // R10 latency: cts falls, visible after third edge
        set_lines(4'b1010);
        idle(2);
        check("R10 early", sts_rdata, 8'hB0);
        idle(1);
        check("R10 landed", sts_rdata, 8'hA1);
        // R9 irq gated by enable
        check("R9 masked", {7'b0, irq_out}, 8'h00);
        msi_en = 1'b1;
        idle(1);
        check("R9 raised", {7'b0, irq_out}, 8'h01);

        // R3 accumulate: dsr falls too
        set_lines(4'b1000);
        idle(4);
        check("R3 accum", sts_rdata, 8'h83);
        // R5 read returns old then clears
        sts_read(rv);
        check("R5 read value", rv, 8'h83);
        check("R5 cleared", sts_rdata, 8'h80);
        check("R9 dropped", {7'b0, irq_out}, 8'h00);

        // R4 ring rising: no flag; falling: flag
        set_lines(4'b1100);
        idle(4);
        check("R4 rise", sts_rdata, 8'hC0);
        set_lines(4'b1000);
        idle(4);
        check("R4 fall", sts_rdata, 8'h84);
        sts_read(rv);

        // R6 control keeps five bits
        ctl_write(8'hEE);
        idle(1);
        check("R6 readback", ctl_rdata, 8'h0E);
        check("R6 pins", {4'b0, rts_out, dtr_out, out1_out, out2_out}, 8'h0B);
        ctl_write(8'h01);
        check("R6 dtr", {4'b0, rts_out, dtr_out, out1_out, out2_out}, 8'h04);

        // R7 loopback: all control bits set -> levels 1111
        ctl_write(8'hFF);
        idle(2);
        check("R6 loop readback", ctl_rdata, 8'h1F);
        check("R8 loop pins", {4'b0, rts_out, dtr_out, out1_out, out2_out}, 8'h03);
        sts_read(rv);
        check("R7 loop levels", rv[7:4], 8'h0F);
        idle(1);
        set_lines(4'b0101);
        idle(5);
        check("R7 pins ignored", sts_rdata, 8'hF0);
        // loop + out1 + dtr -> levels 0110, flags dcd and cts
        ctl_write(8'h15);
        idle(2);
        check("R7 crossed map", sts_rdata, 8'h69);
        // loop only -> levels 0000, ring trailing + dsr accumulate
        ctl_write(8'h10);
        idle(2);
        check("R3 loop accum", sts_rdata, 8'h0F);
        check("R8 out2 follows", {7'b0, out2_out}, 8'h00);
        // leave loopback, pins back in control
        ctl_write(8'h08);
        idle(3);
        sts_read(rv);
        idle(1);
        check("R7 exit levels", sts_rdata, 8'h50);
        cur = 4'b0101;

        // constrained random: one line step per read
        for (int it = 0; it < 300; it++) begin
            nxt = 4'($urandom);
            msi_en = 1'($urandom);
            set_lines(nxt);
            idle(4);
            fl = step_flags(cur, nxt);
            check("R2 step", sts_rdata, {nxt, fl});
            check("R9 step", {7'b0, irq_out}, {7'b0, msi_en & (|fl)});
            sts_read(rv);
            check("R5 step clear", sts_rdata, {nxt, 4'h0});
            cur = nxt;
            if ((it % 8) == 0) begin
                cv = {1'b0, 4'($urandom)};
                ctl_write({3'($urandom), cv});
                check("R6 random ctl", ctl_rdata, {3'b0, cv});
                check("R8 ext pins", {4'b0, rts_out, dtr_out, out1_out, out2_out},
                      {4'b0, cv[1], cv[0], cv[2], cv[3]});
            end
        end
        summary();
    end
endmodule